// File: doc/BRIEF.md
# Thermometer-Path Binary Dot-Product Unit

This unit forms the inner product of two N-bit binary vectors. One vector is a coefficient column held in the unit. The other is an input vector that arrives with a valid strobe. The product is the number of bit positions where both vectors hold a one, so it ranges from 0 to N. The count does not come from an adder tree. The AND of the two vectors is sorted by a network of OR/AND compare-exchange cells into a thermometer code. Each bit of that code is then compared with its upper neighbour to give a one-hot marker. Finally, every marker line selects a fixed binary row, and the selected rows are ORed into the count.

The three conversions are separate registered stages. A new vector may be accepted on every cycle, and its result leaves three cycles later with an output valid. The coefficient column is written through its own strobe and keeps its value until the next write. A malformed-code flag travels with each result. It reports a thermometer word in which a clear bit lies directly below a set bit, which a fault in the sorting stage would produce.

Top module: `tdp_top`

## Requirements
- R1: For each accepted vector, `out_count` equals the number of positions i where `coef[i]` and `in_vec[i]` are both 1.
- R2: `out_count` is $clog2(N+1) bits wide, and a vector that matches the coefficient in all N positions yields exactly N.
- R3: A vector with no position in common with the coefficient yields a count of 0 (the all-zero marker word encodes to 0).
- R4: `out_valid` is high in the cycle three rising edges after the cycle `in_valid` was sampled high, and low three edges after it was sampled low. Back-to-back vectors are accepted every cycle.
- R5: When `coef_we` is sampled high, `coef_in` becomes the coefficient for vectors presented from the next cycle onward. A vector presented in the same cycle as the write still uses the previous coefficient.
- R6: While `coef_we` is low, changes on `coef_in` have no effect on any result.
- R7: `out_malformed` is high with a result if and only if that result's thermometer word held a clear bit at position j and a set bit at position j+1. Bit 0 of that word is set when the count is at least 1, and bit j is set when the count exceeds j. The sorting stage always produces such a word, so the flag stays low for every input.
- R8: After reset, `out_valid`, `out_count` and `out_malformed` are 0 and the coefficient is all zeros, so vectors given before any write produce a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_in | input | N | Coefficient column to write |
| in_valid | input | 1 | Input vector valid |
| in_vec | input | N | Binary input vector |
| out_valid | output | 1 | Result valid, three cycles after input |
| out_count | output | $clog2(N+1) | Binary inner product |
| out_malformed | output | 1 | Thermometer word had a clear-below-set pair |

## Verification
The bench builds the unit with N = 6, which gives a 3-bit count. It runs every coefficient against every input vector, 4096 pairs in all. This reaches every count from 0 to 6 and every matching pattern, and so it exercises every path through the sorting network and every encoder row. Idle cycles are mixed into the stream so that the valid pipeline is seen with gaps as well as back to back. Coefficient writes happen while vectors are in flight, which covers the case where a write and a vector share a cycle.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
    // Default vector length of the unit.
    localparam int unsigned TDP_DEFAULT_N = 16;
    // Number of registered conversion stages between input and result.
    localparam int unsigned TDP_STAGES = 3;
endpackage

// File: rtl/tdp_coef_reg.sv
module tdp_coef_reg #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [N-1:0] din,
    output logic [N-1:0] coef_q
);
    logic [N-1:0] coef_d;

    always_comb begin
        coef_d = coef_q;
        if (we) begin
            coef_d = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coef_q <= '0;
        end else begin
            coef_q <= coef_d;
        end
    end
endmodule

// File: rtl/tdp_therm_sort.sv
// Sorts the ones of a word toward bit 0 with an odd-even transposition
// network of OR/AND compare-exchange cells; the result is a thermometer code.
module tdp_therm_sort #(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0] bits,
    output logic [N-1:0] therm
);
    logic [N-1:0] cur;
    logic [N-1:0] nxt;

    always_comb begin
        cur = bits;
        nxt = bits;
        for (int r = 0; r < int'(N); r++) begin
            nxt = cur;
            for (int i = r % 2; i + 1 < int'(N); i += 2) begin
                nxt[i]   = cur[i] | cur[i+1];
                nxt[i+1] = cur[i] & cur[i+1];
            end
            cur = nxt;
        end
        therm = cur;
    end
endmodule

// File: rtl/tdp_edge_onehot.sv
// Marks the top set bit of a thermometer code and flags clear-below-set pairs.
module tdp_edge_onehot #(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0] therm,
    output logic [N-1:0] onehot,
    output logic         bad
);
    for (genvar j = 0; j < N; j++) begin : g_mark
        if (j == N - 1) begin : g_top
            assign onehot[j] = therm[j];
        end else begin : g_inner
            assign onehot[j] = therm[j] & ~therm[j+1];
        end
    end

    if (N > 1) begin : g_chk
        assign bad = |(~therm[N-2:0] & therm[N-1:1]);
    end else begin : g_nochk
        assign bad = 1'b0;
    end
endmodule

// File: rtl/tdp_onehot_enc.sv
// Each marker line selects a stored row holding (position + 1); rows are ORed.
module tdp_onehot_enc #(
    parameter int unsigned N  = 16,
    parameter int unsigned CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  onehot,
    output logic [CW-1:0] count
);
    always_comb begin
        count = '0;
        for (int j = 0; j < int'(N); j++) begin
            if (onehot[j]) begin
                count = count | CW'(j + 1);
            end
        end
    end
endmodule

// File: rtl/tdp_top.sv
module tdp_top
    import tdp_pkg::*;
#(
    parameter  int unsigned N  = TDP_DEFAULT_N,
    localparam int unsigned CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          coef_we,
    input  logic [N-1:0]  coef_in,
    input  logic          in_valid,
    input  logic [N-1:0]  in_vec,
    output logic          out_valid,
    output logic [CW-1:0] out_count,
    output logic          out_malformed
);
    typedef struct packed {
        logic          v1;
        logic [N-1:0]  th;
        logic          v2;
        logic [N-1:0]  oh;
        logic          e2;
        logic          v3;
        logic [CW-1:0] res;
        logic          e3;
    } pipe_t;

    pipe_t         p_d;
    pipe_t         p_q;
    logic [N-1:0]  coef_q;
    logic [N-1:0]  th_d;
    logic [N-1:0]  th_q;
    logic [N-1:0]  oh_d;
    logic [N-1:0]  oh_q;
    logic          bad_d;
    logic [CW-1:0] res_d;

    tdp_coef_reg #(.N(N)) coef_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (coef_we),
        .din    (coef_in),
        .coef_q (coef_q)
    );

    tdp_therm_sort #(.N(N)) sort_i (
        .bits  (coef_q & in_vec),
        .therm (th_d)
    );

    assign th_q = p_q.th;

    tdp_edge_onehot #(.N(N)) mark_i (
        .therm  (th_q),
        .onehot (oh_d),
        .bad    (bad_d)
    );

    assign oh_q = p_q.oh;

    tdp_onehot_enc #(.N(N), .CW(CW)) enc_i (
        .onehot (oh_q),
        .count  (res_d)
    );

    always_comb begin
        p_d     = p_q;
        p_d.v1  = in_valid;
        p_d.th  = th_d;
        p_d.v2  = p_q.v1;
        p_d.oh  = oh_d;
        p_d.e2  = bad_d;
        p_d.v3  = p_q.v2;
        p_d.res = res_d;
        p_d.e3  = p_q.e2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign out_valid     = p_q.v3;
    assign out_count     = p_q.res;
    assign out_malformed = p_q.e3;
endmodule

// File: rtl/tdp_checker.sv
module tdp_checker #(
    parameter int unsigned N  = 16,
    parameter int unsigned CW = $clog2(N + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          coef_we,
    input logic [N-1:0]  coef_in,
    input logic          out_valid,
    input logic [CW-1:0] out_count,
    input logic          out_malformed,
    input logic [N-1:0]  coef_q,
    input logic [N-1:0]  oh_q
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_count) <= int'(N)));

    assert_no_malformed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_malformed);

    assert_single_marker_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(oh_q));

    assert_coef_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && $past(coef_we)) |-> (coef_q == $past(coef_in)));

    assert_coef_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !$past(coef_we)) |-> $stable(coef_q));
endmodule

bind tdp_top tdp_checker #(.N(N), .CW(CW)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .coef_we       (coef_we),
    .coef_in       (coef_in),
    .out_valid     (out_valid),
    .out_count     (out_count),
    .out_malformed (out_malformed),
    .coef_q        (coef_q),
    .oh_q          (oh_q)
);

// File: tb/tdp_top_tb_top.sv
`timescale 1ns/1ps
module tdp_top_tb_top;
    localparam int unsigned N  = 6;
    localparam int unsigned CW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          coef_we = 1'b0;
    logic [N-1:0]  coef_in = '0;
    logic          in_valid = 1'b0;
    logic [N-1:0]  in_vec = '0;
    logic          out_valid;
    logic [CW-1:0] out_count;
    logic          out_malformed;

    int unsigned   checks = 0;
    int unsigned   errors = 0;
    logic [N-1:0]  model_coef = '0;
    string         phase_tag = "";
    logic          sh_v [3];
    int unsigned   sh_c [3];

    always #2 clk = ~clk;

    tdp_top #(.N(N)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .coef_we       (coef_we),
        .coef_in       (coef_in),
        .in_valid      (in_valid),
        .in_vec        (in_vec),
        .out_valid     (out_valid),
        .out_count     (out_count),
        .out_malformed (out_malformed)
    );

    function automatic int unsigned ones(input logic [N-1:0] x);
        int unsigned n = 0;
        for (int i = 0; i < int'(N); i++) begin
            if (x[i]) n++;
        end
        return n;
    endfunction

    task automatic check(input string tag, input string what,
                         input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Compare outputs with the vector presented three steps earlier.
    task automatic compare_outputs();
        string tag;
        check("R4", "out_valid", int'(out_valid), int'(sh_v[2]));
        if (sh_v[2]) begin
            if (phase_tag != "") tag = phase_tag;
            else if (sh_c[2] == 0) tag = "R3";
            else if (sh_c[2] == N) tag = "R2";
            else tag = "R1";
            check(tag, "out_count", int'(out_count), sh_c[2]);
            check("R7", "out_malformed", int'(out_malformed), 0);
        end
    endtask

    // One cycle: check, record expectation, drive at negedge, advance.
    task automatic step(input logic we, input logic [N-1:0] cin,
                        input logic v, input logic [N-1:0] vec);
        compare_outputs();
        sh_v[2] = sh_v[1]; sh_c[2] = sh_c[1];
        sh_v[1] = sh_v[0]; sh_c[1] = sh_c[0];
        sh_v[0] = v;       sh_c[0] = ones(model_coef & vec);
        coef_we  = we;
        coef_in  = cin;
        in_valid = v;
        in_vec   = vec;
        if (we) model_coef = cin;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R4 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 3; k++) begin
            sh_v[k] = 1'b0;
            sh_c[k] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state at the ports.
        check("R8", "out_valid after reset", int'(out_valid), 0);
        check("R8", "out_count after reset", int'(out_count), 0);
        check("R8", "out_malformed after reset", int'(out_malformed), 0);

        // R8: coefficient starts cleared, so any vector counts 0.
        phase_tag = "R8";
        for (int k = 0; k < 4; k++) step(1'b0, '0, 1'b1, ~N'(k));
        for (int k = 0; k < 3; k++) step(1'b0, '0, 1'b0, '0);

        // R5: write in the same cycle as a vector; that vector sees the old value.
        phase_tag = "R5";
        step(1'b1, '1, 1'b1, '1);
        step(1'b0, '0, 1'b1, '1);
        step(1'b1, N'(6'b010101), 1'b1, '1);
        step(1'b0, '0, 1'b1, '1);
        for (int k = 0; k < 3; k++) step(1'b0, '0, 1'b0, '0);

        // R6: coef_in wiggles without the strobe; results must not move.
        phase_tag = "R6";
        for (int k = 0; k < 16; k++) step(1'b0, N'(k * 37 + 5), 1'b1, N'(k * 11));
        for (int k = 0; k < 3; k++) step(1'b0, '0, 1'b0, '0);

        // R1/R2/R3/R4: every coefficient against every vector, with gaps.
        phase_tag = "";
        for (int c = 0; c < (1 << N); c++) begin
            step(1'b1, N'(c), 1'b0, '0);
            for (int v = 0; v < (1 << N); v++) begin
                if ((v % 9) == 4) step(1'b0, '0, 1'b0, '0);
                step(1'b0, '0, 1'b1, N'(v));
            end
        end
        for (int k = 0; k < 4; k++) step(1'b0, '0, 1'b0, '0);

        finish_run();
    end
endmodule